// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog peripheral clocked from a slow clock of about 32 kHz. A prescaler turns that clock into a count rate of 256 ticks per second, and a 12-bit down-counter measures the time left before a fault. Software keeps the system alive by issuing a keyed restart command. The restart is only legitimate once the counter has fallen to or below a programmed window value. A restart that comes too early is treated as a fault, in the same way as letting the counter run out.

A mode register holds the reload value, the window value, an enable (written as a disable bit), the choice of fault action and two halt qualifiers. Every accepted mode write also restarts the counter. For a short lockout interval after any restart, further writes to the control and mode registers are dropped. A sticky status register records which kind of fault happened, and reading it clears it. A timeout of s seconds is programmed as a reload value of s*256-1.

Top module: `winwdt`

## Requirements
- R1: After reset the block is disabled, and both the reload field and the window field hold 12'hFFF. The status reads 0, the counter reads 12'hFFF, and irq_o and rst_req_o are low.
- R2: While running, the counter decrements once every PRESCALE clock cycles. When a tick arrives with the counter at 0, an underflow fault is raised, status bit 0 is set and the counter reloads. With a restart at edge E and reload R, the fault lands on edge E+(R+1)*PRESCALE.
- R3: A control write (address 0) whose bits 31:24 equal 8'hA5 and whose bit 0 is 1 reloads the counter and clears the prescaler. A wrong key, or a clear bit 0, changes nothing.
- R4: An accepted mode write (address 1) reloads the counter at once from the reload value that is in force after the write.
- R5: After each accepted restart (control or mode), writes to the control and mode registers on the next LOCK_CYC (3) clock edges are ignored. The first write after that interval is accepted.
- R6: Mode bit 31 is the disable bit. A mode write with it set leaves the reload field (bits 11:0) and window field (bits 23:12) unchanged. While disabled, the counter does not decrement.
- R7: A keyed restart while enabled with the counter above the window value raises a fault and sets status bit 1. The counter still reloads.
- R8: With mode bit 24 set, irq_o stays high while any status flag is set. With mode bit 25 set, rst_req_o pulses high for one cycle, in the cycle after each fault event.
- R9: When mode bit 26 is set and idle_i is high, the counter and prescaler hold. The same applies to mode bit 27 and dbg_i. An asserted input whose halt bit is clear has no effect.
- R10: A read of the status register (address 2) returns {bit1 window error, bit0 underflow} and clears both flags on that edge. A flag is set only by its fault event.
- R11: The mode register reads back as {disable, 3'b0, dbg halt, idle halt, reset enable, irq enable, window, reload}. A reload and window of s*256-1 for s from 1 to 16 read back unchanged. Address 3 reads the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 mode, 2 status, 3 counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| idle_i | input | 1 | System idle indication |
| dbg_i | input | 1 | Debugger halt indication |
| irq_o | output | 1 | Fault interrupt, level |
| rst_req_o | output | 1 | Reset request, one-cycle pulse per fault |

## Verification
The bound checker watches on every cycle the following behaviours:
- the one-step decrement on each tick;
- the freezing of the counter while disabled or halted;
- that blocked writes leave the mode fields alone, as does a write with the disable bit set;
- that status flags rise only with their fault events and drop after a status read;
- that the interrupt persists while a flag stands.

Only the bench's scenarios can show the exact cycle of each underflow across a sweep of reload values, the boundary between early and legal restarts across a sweep of restart times, the key decoding, and the edges at which the lockout opens again.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;

  // control word decoding
  localparam int          KEY_HI      = 31;
  localparam int          KEY_LO      = 24;
  localparam logic [7:0]  RESTART_KEY = 8'hA5;
  localparam int          GO_BIT      = 0;

  // mode word flag positions (fields occupy the low 2*CNT_W bits)
  localparam int MB_IRQ  = 24;
  localparam int MB_RST  = 25;
  localparam int MB_IDLE = 26;
  localparam int MB_DBG  = 27;
  localparam int MB_DIS  = 31;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2,
    A_CNT  = 2'd3
  } addr_e;

  typedef struct packed {
    logic dis;
    logic dbg_halt;
    logic idle_halt;
    logic rst_en;
    logic irq_en;
  } mode_flags_t;

  // timeout in seconds to reload value
  function automatic int unsigned secs_to_ticks(int unsigned secs, int unsigned tps);
    return (secs == 0) ? 0 : secs * tps - 1;
  endfunction

  function automatic logic restart_cmd(logic [7:0] key, logic go);
    return (key == RESTART_KEY) && go;
  endfunction

  function automatic logic outside_window(logic [15:0] cnt, logic [15:0] win);
    return cnt > win;
  endfunction

endpackage

// File: rtl/winwdt_prescaler.sv
module winwdt_prescaler #(
  parameter int PRESCALE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);

  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      logic [PW-1:0] div_q;
      assign tick = run && (div_q == PW'(PRESCALE - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= '0;
        else if (clear)  div_q <= '0;
        else if (run)    div_q <= tick ? '0 : div_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/winwdt_counter.sv
module winwdt_counter
  import winwdt_pkg::*;
#(
  parameter int           CNT_W   = 12,
  parameter logic [CNT_W-1:0] DEF_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] win,
  input  logic             enabled,
  input  logic             key_restart,
  output logic [CNT_W-1:0] cnt,
  output logic             uf_evt,
  output logic             win_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign uf_evt  = tick && at_zero && !load;
  assign win_evt = key_restart && enabled &&
                   outside_window(16'(cnt_q), 16'(win));
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= DEF_VAL;
    else if (load)  cnt_q <= load_val;
    else if (tick)  cnt_q <= at_zero ? reload : cnt_q - 1'b1;
  end

endmodule

// File: rtl/winwdt_regs.sv
module winwdt_regs
  import winwdt_pkg::*;
#(
  parameter int           CNT_W    = 12,
  parameter int           LOCK_CYC = 3,
  parameter logic [CNT_W-1:0] DEF_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             uf_evt,
  input  logic             win_evt,
  output logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] win,
  output mode_flags_t      flags,
  output logic             key_restart,
  output logic             mode_load,
  output logic             load_any,
  output logic [CNT_W-1:0] load_val,
  output logic             wr_blocked,
  output logic             stat_rd,
  output logic             st_uf,
  output logic             st_win,
  output logic             irq_o,
  output logic             rst_req_o
);

  localparam int LW = (LOCK_CYC < 1) ? 1 : $clog2(LOCK_CYC + 1);

  logic [LW-1:0]    lock_q;
  logic             locked;
  logic             wr_ctrl, wr_mode, fields_upd;
  logic [CNT_W-1:0] reload_q, win_q;
  mode_flags_t      flags_q;
  logic             st_uf_q, st_win_q, rst_req_q;
  logic [31:0]      mode_rd;
  logic             unused_wdata;

  assign unused_wdata = &{1'b0, bus_wdata[30:28]};

  assign locked      = (lock_q != '0);
  assign wr_ctrl     = bus_sel && bus_wr  && (bus_addr == A_CTRL);
  assign wr_mode     = bus_sel && bus_wr  && (bus_addr == A_MODE);
  assign stat_rd     = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign key_restart = wr_ctrl && !locked &&
                       restart_cmd(bus_wdata[KEY_HI:KEY_LO], bus_wdata[GO_BIT]);
  assign mode_load   = wr_mode && !locked;
  assign load_any    = key_restart || mode_load;
  assign wr_blocked  = (wr_ctrl || wr_mode) && locked;
  assign fields_upd  = mode_load && !bus_wdata[MB_DIS];
  assign load_val    = fields_upd ? bus_wdata[CNT_W-1:0] : reload_q;

  // restart lockout
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= '0;
    else if (load_any) lock_q <= LW'(LOCK_CYC);
    else if (locked)   lock_q <= lock_q - 1'b1;
  end

  // mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= DEF_VAL;
      win_q    <= DEF_VAL;
      flags_q  <= '{dis: 1'b1, default: 1'b0};
    end else if (mode_load) begin
      flags_q.dis       <= bus_wdata[MB_DIS];
      flags_q.dbg_halt  <= bus_wdata[MB_DBG];
      flags_q.idle_halt <= bus_wdata[MB_IDLE];
      flags_q.rst_en    <= bus_wdata[MB_RST];
      flags_q.irq_en    <= bus_wdata[MB_IRQ];
      if (fields_upd) begin
        reload_q <= bus_wdata[CNT_W-1:0];
        win_q    <= bus_wdata[2*CNT_W-1:CNT_W];
      end
    end
  end

  // sticky status, fault actions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_uf_q   <= 1'b0;
      st_win_q  <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      st_uf_q   <= uf_evt  || (st_uf_q  && !stat_rd);
      st_win_q  <= win_evt || (st_win_q && !stat_rd);
      rst_req_q <= (uf_evt || win_evt) && flags_q.rst_en;
    end
  end

  always_comb begin
    mode_rd                   = '0;
    mode_rd[CNT_W-1:0]        = reload_q;
    mode_rd[2*CNT_W-1:CNT_W]  = win_q;
    mode_rd[MB_IRQ]           = flags_q.irq_en;
    mode_rd[MB_RST]           = flags_q.rst_en;
    mode_rd[MB_IDLE]          = flags_q.idle_halt;
    mode_rd[MB_DBG]           = flags_q.dbg_halt;
    mode_rd[MB_DIS]           = flags_q.dis;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_MODE:  bus_rdata = mode_rd;
        A_STAT:  bus_rdata = {30'd0, st_win_q, st_uf_q};
        A_CNT:   bus_rdata = 32'(cnt);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign reload    = reload_q;
  assign win       = win_q;
  assign flags     = flags_q;
  assign st_uf     = st_uf_q;
  assign st_win    = st_win_q;
  assign irq_o     = flags_q.irq_en && (st_uf_q || st_win_q);
  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/winwdt.sv
module winwdt
  import winwdt_pkg::*;
#(
  parameter int CNT_W         = 12,
  parameter int PRESCALE      = 128,
  parameter int LOCK_CYC      = 3,
  parameter int TICKS_PER_SEC = 256,
  parameter int DEF_SECS      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        idle_i,
  input  logic        dbg_i,
  output logic        irq_o,
  output logic        rst_req_o
);

  localparam logic [CNT_W-1:0] DEF_VAL = CNT_W'(secs_to_ticks(DEF_SECS, TICKS_PER_SEC));

  logic [CNT_W-1:0] reload_w, win_w, load_val_w, cnt_w;
  mode_flags_t      flags_w;
  logic             key_restart_w, mode_load_w, load_w, wr_blocked;
  logic             stat_rd_w, st_uf, st_win;
  logic             uf_evt, win_evt, tick_w, run_w, halted_w, enabled_w;
  logic             wr_dis_bit;

  assign enabled_w  = !flags_w.dis;
  assign halted_w   = (flags_w.idle_halt && idle_i) || (flags_w.dbg_halt && dbg_i);
  assign run_w      = enabled_w && !halted_w;
  assign wr_dis_bit = bus_wdata[MB_DIS];

  winwdt_regs #(
    .CNT_W(CNT_W), .LOCK_CYC(LOCK_CYC), .DEF_VAL(DEF_VAL)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_w), .uf_evt(uf_evt), .win_evt(win_evt),
    .reload(reload_w), .win(win_w), .flags(flags_w),
    .key_restart(key_restart_w), .mode_load(mode_load_w), .load_any(load_w),
    .load_val(load_val_w), .wr_blocked(wr_blocked), .stat_rd(stat_rd_w),
    .st_uf(st_uf), .st_win(st_win), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  winwdt_prescaler #(.PRESCALE(PRESCALE)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run_w), .clear(load_w), .tick(tick_w)
  );

  winwdt_counter #(.CNT_W(CNT_W), .DEF_VAL(DEF_VAL)) cnt_i (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .load(load_w),
    .load_val(load_val_w), .reload(reload_w), .win(win_w),
    .enabled(enabled_w), .key_restart(key_restart_w),
    .cnt(cnt_w), .uf_evt(uf_evt), .win_evt(win_evt)
  );

endmodule

// File: rtl/winwdt_chk.sv
module winwdt_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_blocked,
  input logic             mode_load,
  input logic             wr_dis_bit,
  input logic             load,
  input logic             tick,
  input logic             dis,
  input logic             halted,
  input logic             irq_en,
  input logic [4:0]       flags,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] win,
  input logic [CNT_W-1:0] cnt,
  input logic             uf_evt,
  input logic             win_evt,
  input logic             stat_rd,
  input logic             st_uf,
  input logic             st_win,
  input logic             irq_o,
  input logic             rst_req_o
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

  // R2
  uf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> st_uf);

  // R5
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> ($stable(reload) && $stable(win) && $stable(flags)));

  // R6
  dis_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && wr_dis_bit) |=> ($stable(reload) && $stable(win)));

  // R6
  dis_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !load) |=> $stable(cnt));

  // R7
  win_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> st_win);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_en && !stat_rd && !mode_load) |=> irq_o);

  // R8
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(uf_evt || win_evt));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load) |=> $stable(cnt));

  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !uf_evt && !win_evt) |=> (!st_uf && !st_win));

  // R10
  uf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_uf) |-> $past(uf_evt));

  // R10
  win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_win) |-> $past(win_evt));

endmodule

bind winwdt winwdt_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .wr_blocked(wr_blocked), .mode_load(mode_load_w), .wr_dis_bit(wr_dis_bit),
  .load(load_w), .tick(tick_w), .dis(flags_w.dis), .halted(halted_w),
  .irq_en(flags_w.irq_en), .flags(flags_w),
  .reload(reload_w), .win(win_w), .cnt(cnt_w),
  .uf_evt(uf_evt), .win_evt(win_evt), .stat_rd(stat_rd_w),
  .st_uf(st_uf), .st_win(st_win), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/winwdt_tb_top.sv
module winwdt_tb_top;

  localparam int P    = 2;
  localparam int LOCK = 3;
  localparam logic [1:0] AD_CTRL = 2'd0, AD_MODE = 2'd1, AD_STAT = 2'd2, AD_CNT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        idle_i = 1'b0, dbg_i = 1'b0;
  logic        irq_o, rst_req_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  winwdt #(.CNT_W(12), .PRESCALE(P), .LOCK_CYC(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .idle_i(idle_i), .dbg_i(dbg_i), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  function automatic logic [31:0] mw(int rl, int wn, bit ie, bit re, bit ih, bit dh, bit ds);
    logic [11:0] r12 = 12'(rl);
    logic [11:0] w12 = 12'(wn);
    return {ds, 3'b000, dh, ih, re, ie, w12, r12};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all bus tasks start at a negedge and end at the next negedge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic gap();
    repeat (LOCK) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rst_req", 32'(rst_req_o), 0);
    rd(AD_MODE, d); chk("R1 mode", d, mw(4095, 4095, 0, 0, 0, 0, 1));
    rd(AD_STAT, d); chk("R1 status", d, 0);
    rd(AD_CNT, d);  chk("R1 counter", d, 32'hFFF);
    repeat (20) @(negedge clk);
    rd(AD_CNT, d);  chk("R6 frozen while disabled", d, 32'hFFF);

    // R2 underflow timing sweep, R10 read-clear
    for (int r = 0; r < 8; r++) begin
      wr(AD_MODE, mw(r, 4095, 1, 0, 0, 0, 0));
      repeat ((r + 1) * P - 1) @(negedge clk);
      chk($sformatf("R2 no fault yet reload=%0d", r), 32'(irq_o), 0);
      @(negedge clk);
      chk($sformatf("R2 fault edge reload=%0d", r), 32'(irq_o), 1);
      gap();
      wr(AD_MODE, mw(r, 4095, 1, 0, 0, 0, 1));
      rd(AD_STAT, d); chk("R10 underflow flag", d, 1);
      rd(AD_STAT, d); chk("R10 cleared by read", d, 0);
      chk("R10 irq after clear", 32'(irq_o), 0);
      gap();
    end

    // R2 decrement rate
    wr(AD_MODE, mw(20, 4095, 0, 0, 0, 0, 0));
    for (int j = 0; j < 30; j++) begin
      rd(AD_CNT, d); chk($sformatf("R2 count j=%0d", j), d, 32'(20 - j / P));
    end

    // R3 keyed restart and rejected commands
    wr(AD_CTRL, 32'hA500_0001);                     // edge F
    rd(AD_CNT, d); chk("R3 restart reloads", d, 20); // F+1
    repeat (3) @(negedge clk);                      // after F+4
    wr(AD_CTRL, 32'h5A00_0001);                     // F+5 wrong key
    rd(AD_CNT, d); chk("R3 wrong key ignored", d, 32'(20 - 5 / P));
    wr(AD_CTRL, 32'hA500_0000);                     // F+7 no restart bit
    rd(AD_CNT, d); chk("R3 missing restart bit ignored", d, 32'(20 - 7 / P));

    // R5 lockout window
    wr(AD_CTRL, 32'hA500_0001);                     // G
    wr(AD_MODE, mw(7, 4095, 0, 0, 0, 0, 0));        // G+1 blocked
    wr(AD_CTRL, 32'hA500_0001);                     // G+2 blocked
    wr(AD_MODE, mw(8, 4095, 0, 0, 0, 0, 0));        // G+3 blocked
    rd(AD_CNT, d);  chk("R5 restart blocked", d, 32'(20 - 3 / P));
    rd(AD_MODE, d); chk("R5 mode write blocked", d, mw(20, 4095, 0, 0, 0, 0, 0));
    // R4 first write after lockout accepted, reloads from new value
    wr(AD_MODE, mw(9, 4095, 0, 0, 0, 0, 0));        // G+6
    rd(AD_CNT, d);  chk("R4 mode write reloads", d, 9);
    rd(AD_MODE, d); chk("R5 write after lockout", d, mw(9, 4095, 0, 0, 0, 0, 0));

    // R6 disable write keeps fields and freezes
    gap();
    wr(AD_MODE, mw(3, 5, 0, 0, 0, 0, 1));
    rd(AD_MODE, d); chk("R6 fields kept", d, mw(9, 4095, 0, 0, 0, 0, 1));
    rd(AD_CNT, d);  chk("R6 counter reloaded", d, 9);
    repeat (20) @(negedge clk);
    rd(AD_CNT, d);  chk("R6 counter frozen", d, 9);

    // R7 window sweep: reload 10, window 4
    for (int m = 4; m <= 20; m++) begin
      bit err;
      gap();
      wr(AD_MODE, mw(10, 4, 1, 0, 0, 0, 0));        // E
      repeat (m - 1) @(negedge clk);
      wr(AD_CTRL, 32'hA500_0001);                   // E+m
      err = ((10 - (m - 1) / P) > 4);
      chk($sformatf("R7 irq m=%0d", m), 32'(irq_o), 32'(err));
      rd(AD_STAT, d);
      chk($sformatf("R7 status m=%0d", m), d, err ? 32'd2 : 32'd0);
    end
    gap();
    wr(AD_MODE, mw(10, 4, 0, 0, 0, 0, 1));
    rd(AD_STAT, d);
    gap();

    // R8 reset request pulse
    wr(AD_MODE, mw(1, 4095, 0, 1, 0, 0, 0));        // E
    repeat (3) @(negedge clk);
    chk("R8 rst before fault", 32'(rst_req_o), 0);
    @(negedge clk);
    chk("R8 rst pulse", 32'(rst_req_o), 1);
    chk("R8 irq masked", 32'(irq_o), 0);
    @(negedge clk);
    chk("R8 rst one cycle", 32'(rst_req_o), 0);
    gap();
    wr(AD_MODE, mw(1, 4095, 0, 0, 0, 0, 1));
    rd(AD_STAT, d); chk("R10 flag after rst fault", d, 1);
    gap();

    // R9 idle halt
    idle_i = 1'b1;
    wr(AD_MODE, mw(2, 4095, 1, 0, 1, 0, 0));
    repeat (40) @(negedge clk);
    chk("R9 idle holds irq", 32'(irq_o), 0);
    rd(AD_CNT, d); chk("R9 idle holds counter", d, 2);
    idle_i = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 resume no fault yet", 32'(irq_o), 0);
    @(negedge clk);
    chk("R9 resume fault", 32'(irq_o), 1);
    gap();
    wr(AD_MODE, mw(2, 4095, 0, 0, 0, 0, 1));
    rd(AD_STAT, d);
    gap();

    // R9 debug input without and with its halt bit
    dbg_i = 1'b1;
    wr(AD_MODE, mw(20, 4095, 0, 0, 0, 0, 0));       // E
    repeat (2) @(negedge clk);
    rd(AD_CNT, d); chk("R9 dbg ignored without bit", d, 32'(20 - 2 / P));
    repeat (2) @(negedge clk);
    wr(AD_MODE, mw(20, 4095, 0, 0, 0, 1, 0));
    repeat (30) @(negedge clk);
    rd(AD_CNT, d); chk("R9 dbg halt holds", d, 20);
    dbg_i = 1'b0;

    // R11 seconds mapping readback
    for (int s = 1; s <= 16; s++) begin
      gap();
      wr(AD_MODE, mw(s * 256 - 1, s * 256 - 1, 0, 0, 0, 0, 0));
      rd(AD_MODE, d);
      chk($sformatf("R11 readback s=%0d", s), d, mw(s * 256 - 1, s * 256 - 1, 0, 0, 0, 0, 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule